// File: doc/BRIEF.md
# Return Address Stack

This block holds the return addresses of nested subroutine calls and interrupts for a processor core. The core pulses a push strobe with the address to save, and a pop strobe to take the newest address back. The newest entry is always visible on a top-of-stack output. A small byte-wide register port lets software read and write the stack pointer, the status flags and the newest entry. That is enough for software to move the hardware stack to memory and restore it later.

The storage has 31 entries of 21 bits and is indexed by a 5-bit pointer. Pointer value 0 means the stack is empty and has no storage behind it. A push first advances the pointer and then writes the new entry there. A pop presents the entry under the pointer and then steps the pointer back. A push onto a full stack and a pop from an empty stack are both refused, and each sets a sticky error flag. Decoding which instructions push or pop, and any reaction to a stack error, belong to the logic around this block.

Top module: `ret_stack`

## Requirements
- R1: After reset the pointer is 0, the full, overflow and underflow flags are 0, and `tos_o` is 0.
- R2: A push with the pointer below 31 increments the pointer on the clock edge and stores `push_addr_i` at the new pointer, so `tos_o` shows that value from the next cycle.
- R3: During a pop cycle `tos_o` carries the entry under the current pointer as the return address, and on the clock edge the pointer decrements; entries come back in last-in, first-out order.
- R4: `full_o` is 1 exactly when the pointer equals 31.
- R5: A push with the pointer at 31 sets the overflow flag, leaves the pointer at 31 and changes no stored entry.
- R6: A pop with the pointer at 0 sets the underflow flag, presents 0 on `tos_o` and leaves the pointer at 0.
- R7: The overflow and underflow flags are sticky: once set they stay set through any later push or pop, and only reset or a bus write to register 0 changes them.
- R8: Bus register 0 (`bus_sel_i`=0) reads as {overflow (bit 7), underflow (bit 6), full (bit 5), pointer (bits 4:0)}; a write loads the pointer from bits 4:0, underflow from bit 6 and overflow from bit 7, and bit 5 is ignored.
- R9: Bus registers 1, 2 and 3 read and write bits 7:0, bits 15:8 and bits 20:16 of the entry under the pointer; register 3 reads 0 in bits 7:5, and those bits are dropped on a write.
- R10: While the pointer is 0, reads of registers 1 to 3 return 0 and writes to them change no stored entry.
- R11: A bus write in the same cycle as a push or pop takes effect and the push or pop is dropped; a push and a pop in the same cycle act as a push alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe, one entry per cycle |
| push_addr_i | input | 21 | Address to save on a push |
| pop_i | input | 1 | Pop strobe, one entry per cycle |
| tos_o | output | 21 | Entry under the pointer, 0 when the stack is empty |
| full_o | output | 1 | Pointer is at 31 |
| overflow_o | output | 1 | Sticky flag for a push refused on a full stack |
| underflow_o | output | 1 | Sticky flag for a pop refused on an empty stack |
| bus_sel_i | input | 2 | Register select: 0 pointer/status, 1 low byte, 2 high byte, 3 upper bits |
| bus_we_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data for the selected register, combinational |

## Verification
The bench fills the stack to 31 entries and pushes once more. A design that wraps the pointer or writes past the end would lose the overflow flag, or would return a wrong value when the stack is popped all the way back in LIFO order. It then pops an empty stack, where a wrap to 31 or a non-zero return value shows up at once. It also checks that both flags survive later traffic and clear only through the pointer register. Writes to the top-entry bytes are made with the pointer at 0, which would corrupt entry 1 if they were not ignored. Same-cycle collisions between a bus write, a push and a pop are driven to confirm the stated priority.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
    // bus register map; the status bit positions in register 0 are fixed
    typedef enum logic [1:0] {
        REG_PTR   = 2'd0,
        REG_LOW   = 2'd1,
        REG_HIGH  = 2'd2,
        REG_UPPER = 2'd3
    } reg_sel_e;

    localparam int OVF_BIT  = 7;
    localparam int UNF_BIT  = 6;
    localparam int FULL_BIT = 5;
endpackage

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
    parameter int AW    = 21,
    parameter int PTR_W = 5,
    localparam int DEPTH = (1 << PTR_W) - 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [AW-1:0]    wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [AW-1:0]    rdata
);
    // location 0 has no storage; entries 1..DEPTH only
    logic [AW-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && waddr == PTR_W'(g + 1)) begin
                entry_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr != '0) begin
            rdata = entry_q[raddr - PTR_W'(1)];
        end
    end
endmodule

// File: rtl/ret_stack_busif.sv
module ret_stack_busif
    import ret_stack_pkg::*;
#(
    parameter int AW    = 21,
    parameter int PTR_W = 5,
    localparam int UW   = AW - 16
) (
    input  logic [1:0]       sel,
    input  logic [7:0]       wdata,
    input  logic [AW-1:0]    tos,
    input  logic [PTR_W-1:0] ptr,
    input  logic             full,
    input  logic             ovf,
    input  logic             unf,
    output logic [7:0]       rdata,
    output logic [AW-1:0]    tos_merged
);
    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(sel))
            REG_PTR: begin
                rdata[PTR_W-1:0] = ptr;
                rdata[FULL_BIT]  = full;
                rdata[UNF_BIT]   = unf;
                rdata[OVF_BIT]   = ovf;
            end
            REG_LOW:   rdata = tos[7:0];
            REG_HIGH:  rdata = tos[15:8];
            REG_UPPER: rdata[UW-1:0] = tos[AW-1:16];
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        tos_merged = tos;
        unique case (reg_sel_e'(sel))
            REG_LOW:   tos_merged[7:0]   = wdata;
            REG_HIGH:  tos_merged[15:8]  = wdata;
            REG_UPPER: tos_merged[AW-1:16] = wdata[UW-1:0];
            default:   tos_merged = tos;
        endcase
    end
endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
    import ret_stack_pkg::*;
#(
    parameter int AW    = 21,
    parameter int PTR_W = 5,
    localparam int DEPTH = (1 << PTR_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  logic             pop,
    input  logic             bus_we,
    input  logic [1:0]       bus_sel,
    input  logic [7:0]       bus_wdata,
    input  logic [AW-1:0]    tos_merged,
    output logic [PTR_W-1:0] ptr,
    output logic             full,
    output logic             ovf,
    output logic             unf,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_waddr,
    output logic [AW-1:0]    mem_wdata
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             ovf;
        logic             unf;
    } state_t;

    localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_waddr = st_q.ptr;
        mem_wdata = tos_merged;
        if (bus_we) begin
            if (reg_sel_e'(bus_sel) == REG_PTR) begin
                st_d.ptr = bus_wdata[PTR_W-1:0];
                st_d.unf = bus_wdata[UNF_BIT];
                st_d.ovf = bus_wdata[OVF_BIT];
            end else if (st_q.ptr != '0) begin
                mem_we = 1'b1;
            end
        end else if (push) begin
            if (st_q.ptr == TOP) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.ptr  = st_q.ptr + PTR_W'(1);
                mem_we    = 1'b1;
                mem_waddr = st_q.ptr + PTR_W'(1);
                mem_wdata = push_addr;
            end
        end else if (pop) begin
            if (st_q.ptr == '0) begin
                st_d.unf = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr - PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr  = st_q.ptr;
    assign ovf  = st_q.ovf;
    assign unf  = st_q.unf;
    assign full = (st_q.ptr == TOP);

    // R2: push below the top advances the pointer by one
    a_r2_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !bus_we && ptr != TOP) |=> ptr == $past(ptr) + PTR_W'(1));
    // R3: pop of a non-empty stack steps the pointer back by one
    a_r3_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !bus_we && ptr != '0) |=> ptr == $past(ptr) - PTR_W'(1));
    // R5: refused push keeps the pointer and raises overflow
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !bus_we && ptr == TOP) |=> (ptr == TOP && ovf));
    // R5: refused push never writes storage
    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !bus_we && ptr == TOP) |-> !mem_we);
    // R6: refused pop keeps the pointer and raises underflow
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !bus_we && ptr == '0) |=> (ptr == '0 && unf));
    // R7: flags only drop through a bus write
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !bus_we) |=> ovf);
    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !bus_we) |=> unf);
    // R11: a bus write wins over a push
    a_r11_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel_e'(bus_sel) != REG_PTR) |=> $stable(ptr));
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int AW    = 21,
    parameter int PTR_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    output logic [AW-1:0] tos_o,
    output logic          full_o,
    output logic          overflow_o,
    output logic          underflow_o,
    input  logic [1:0]    bus_sel_i,
    input  logic          bus_we_i,
    input  logic [7:0]    bus_wdata_i,
    output logic [7:0]    bus_rdata_o
);
    logic [PTR_W-1:0] ptr, mem_waddr;
    logic [AW-1:0]    tos_merged, mem_wdata;
    logic             mem_we;

    ret_stack_ctrl #(.AW(AW), .PTR_W(PTR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_i),
        .push_addr  (push_addr_i),
        .pop        (pop_i),
        .bus_we     (bus_we_i),
        .bus_sel    (bus_sel_i),
        .bus_wdata  (bus_wdata_i),
        .tos_merged (tos_merged),
        .ptr        (ptr),
        .full       (full_o),
        .ovf        (overflow_o),
        .unf        (underflow_o),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    ret_stack_mem #(.AW(AW), .PTR_W(PTR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr),
        .rdata (tos_o)
    );

    ret_stack_busif #(.AW(AW), .PTR_W(PTR_W)) u_busif (
        .sel        (bus_sel_i),
        .wdata      (bus_wdata_i),
        .tos        (tos_o),
        .ptr        (ptr),
        .full       (full_o),
        .ovf        (overflow_o),
        .unf        (underflow_o),
        .rdata      (bus_rdata_o),
        .tos_merged (tos_merged)
    );

    // R10: an empty stack shows no entry
    a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0) |-> (tos_o == '0));
    // R6: refused pop returns zero
    a_r6_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && ptr == '0) |-> (tos_o == '0));
endmodule

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, pop_i = 1'b0, bus_we_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic [1:0]    bus_sel_i = '0;
    logic [7:0]    bus_wdata_i = '0;
    logic [AW-1:0] tos_o;
    logic          full_o, overflow_o, underflow_o;
    logic [7:0]    bus_rdata_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    ret_stack u_ret_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
        .pop_i(pop_i), .tos_o(tos_o), .full_o(full_o), .overflow_o(overflow_o),
        .underflow_o(underflow_o), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o)
    );

    function automatic logic [AW-1:0] pat(int i);
        return AW'((i * 21'h0A5A5 + 3) & 21'h1FFFFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_push(logic [AW-1:0] v);
        @(negedge clk); push_i = 1'b1; push_addr_i = v;
        @(negedge clk); push_i = 1'b0; #1;
    endtask

    task automatic do_pop(string req, logic [AW-1:0] exp);
        @(negedge clk); pop_i = 1'b1; #1;
        chk(req, 32'(tos_o), 32'(exp));
        @(negedge clk); pop_i = 1'b0; #1;
    endtask

    task automatic bus_wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk); bus_we_i = 1'b1; bus_sel_i = s; bus_wdata_i = d;
        @(negedge clk); bus_we_i = 1'b0; #1;
    endtask

    task automatic bus_rd(logic [1:0] s, output logic [7:0] d);
        bus_sel_i = s; #1; d = bus_rdata_o;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        bus_rd(2'd0, r);
        chk("R1 status", 32'(r), 32'h00);
        chk("R1 tos", 32'(tos_o), 0);
        chk("R1 full", 32'(full_o), 0);
    endtask

    task automatic t_basic();
        logic [7:0] r;
        do_push(21'h001A34); do_push(21'h000D58); do_push(21'h1F00FF);
        bus_rd(2'd0, r);
        chk("R2 ptr after 3 pushes", 32'(r), 32'h03);
        chk("R2 tos", 32'(tos_o), 32'h1F00FF);
        bus_rd(2'd3, r); chk("R9 upper read", 32'(r), 32'h1F);
        bus_rd(2'd2, r); chk("R9 high read", 32'(r), 32'h00);
        bus_rd(2'd1, r); chk("R9 low read", 32'(r), 32'hFF);
        do_pop("R3 return value", 21'h1F00FF);
        chk("R3 tos after pop", 32'(tos_o), 32'h000D58);
        do_pop("R3 second", 21'h000D58);
        do_pop("R3 third", 21'h001A34);
        bus_rd(2'd0, r); chk("R3 ptr empty", 32'(r), 32'h00);
    endtask

    task automatic t_fill_overflow();
        logic [7:0] r;
        for (int i = 1; i <= 31; i++) begin
            do_push(pat(i));
            if (i == 30) chk("R4 not full at 30", 32'(full_o), 0);
        end
        chk("R4 full at 31", 32'(full_o), 1);
        chk("R5 ovf clear before", 32'(overflow_o), 0);
        do_push(21'h1FFFFF);
        chk("R5 ovf set", 32'(overflow_o), 1);
        bus_rd(2'd0, r); chk("R8 status full+ovf", 32'(r), 32'hBF);
        chk("R5 top unchanged", 32'(tos_o), 32'(pat(31)));
        for (int i = 31; i >= 1; i--) begin
            do_pop("R3 LIFO order", pat(i));
        end
        do_pop("R6 empty pop returns zero", '0);
        chk("R6 unf set", 32'(underflow_o), 1);
        bus_rd(2'd0, r); chk("R6 ptr stays 0", 32'(r), 32'hC0);
    endtask

    task automatic t_sticky();
        logic [7:0] r;
        do_push(21'h012345);
        do_pop("R7 pop after flags", 21'h012345);
        chk("R7 ovf sticky", 32'(overflow_o), 1);
        chk("R7 unf sticky", 32'(underflow_o), 1);
        bus_wr(2'd0, 8'h62);                 // unf=1, full bit ignored, ptr=2
        bus_rd(2'd0, r); chk("R8 write loads", 32'(r), 32'h42);
        bus_wr(2'd0, 8'h02);
        bus_rd(2'd0, r); chk("R7 cleared by bus", 32'(r), 32'h02);
    endtask

    task automatic t_tos_write();
        logic [7:0] r;
        // pointer is 2; entry 1 still holds the last pushed value
        bus_wr(2'd1, 8'h5A); bus_wr(2'd2, 8'hC3); bus_wr(2'd3, 8'hFF);
        chk("R9 tos written", 32'(tos_o), 32'h1FC35A);
        bus_rd(2'd3, r); chk("R9 upper bits 7:5 zero", 32'(r), 32'h1F);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h77); bus_wr(2'd3, 8'h0A);
        bus_rd(2'd1, r); chk("R10 empty low read", 32'(r), 0);
        chk("R10 empty tos", 32'(tos_o), 0);
        bus_wr(2'd0, 8'h01);
        chk("R10 entry 1 untouched", 32'(tos_o), 32'h012345);
    endtask

    task automatic t_priority();
        logic [7:0] r;
        @(negedge clk); push_i = 1'b1; pop_i = 1'b1; push_addr_i = 21'h0ABCDE;
        @(negedge clk); push_i = 1'b0; pop_i = 1'b0; #1;
        bus_rd(2'd0, r); chk("R11 push beats pop ptr", 32'(r), 32'h02);
        chk("R11 push beats pop tos", 32'(tos_o), 32'h0ABCDE);
        @(negedge clk); push_i = 1'b1; push_addr_i = 21'h111111;
        bus_we_i = 1'b1; bus_sel_i = 2'd0; bus_wdata_i = 8'h05;
        @(negedge clk); push_i = 1'b0; bus_we_i = 1'b0; #1;
        bus_rd(2'd0, r); chk("R11 bus beats push", 32'(r), 32'h05);
        @(negedge clk); pop_i = 1'b1; bus_we_i = 1'b1; bus_sel_i = 2'd1; bus_wdata_i = 8'h00;
        @(negedge clk); pop_i = 1'b0; bus_we_i = 1'b0; #1;
        bus_rd(2'd0, r); chk("R11 bus beats pop", 32'(r), 32'h05);
    endtask

    initial begin
        #200000;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_basic();
        t_fill_overflow();
        t_sticky();
        t_tos_write();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule